// File: doc/BRIEF.md
# Half-Bridge Dead-Time Sequencer

This block sits between motor-control logic and the gate drivers of six half-bridges. Each half-bridge has a high-side and a low-side switch. For every channel the block takes a requested enable for each switch and produces registered gate enables. It guarantees that the two switches of a pair are never on together. Each switch is still commanded on its own, so a channel can serve as a single quarter-bridge switch or as a full half-bridge. Brake, forward, reverse and float are built by a controller that pairs two channels.

Changing over from one switch to the other inserts a minimum idle gap. The gap differs by direction: high-to-low is shorter than low-to-high. Both gaps are counted in system clock cycles from parameters. At 125 MHz the defaults are 188 and 313 cycles, which gives 1.5 µs and 2.5 µs. A fault input for each switch, and a global all-off input, turn switches off at the next clock with no waiting. The dead time is still honoured on the next changeover.

Top module: `hb_deadtime_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every `hs_en` and `ls_en` bit is 0.
- R2: For no channel are `hs_en[i]` and `ls_en[i]` both 1 in any cycle.
- R3: When a channel's high-side enable falls and only its low-side is requested, `ls_en` rises exactly `DT_HL_CYC` cycles after `hs_en` fell, and it stays 0 in between.
- R4: When a channel's low-side enable falls and only its high-side is requested, `hs_en` rises exactly `DT_LH_CYC` cycles after `ls_en` fell, and it stays 0 in between.
- R5: A request for a switch with no opposite-side changeover pending is reflected one clock later. This covers the first turn-on after reset and re-enabling the switch that was last on.
- R6: If both switches of a channel are requested while one is on, the one that is on stays on and the other stays off.
- R7: If both switches of a channel are requested while both are off, neither turns on until one request is withdrawn.
- R8: `hs_fault[i]` or `ls_fault[i]` high at a clock edge forces that switch off at that edge, whatever the request. The following opposite-side turn-on still waits the full dead time.
- R9: `all_off` high at a clock edge forces every switch of every channel off at that edge.
- R10: Channels are independent: events on one channel do not change the enables of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_req | input | N_CH | Requested high-side enable per channel |
| ls_req | input | N_CH | Requested low-side enable per channel |
| hs_fault | input | N_CH | Immediate high-side shutdown per channel |
| ls_fault | input | N_CH | Immediate low-side shutdown per channel |
| all_off | input | 1 | Immediate shutdown of every switch |
| hs_en | output | N_CH | Registered high-side gate enable |
| ls_en | output | N_CH | Registered low-side gate enable |

## Verification
Two functions can fall in the same cycle: a forced shutdown and a changeover request. The bench provokes this by raising a low-side fault in the same cycle that the low-side request is dropped and the high-side request is raised. It then checks that the low-side enable falls on the very next clock, and that the high-side waits the complete low-to-high gap from that forced edge. A second collision releases `all_off` while a channel holds both requests. That channel must stay fully off, while its neighbours resume their last side at once.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  // Which switch of a pair was turned off most recently.
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HS   = 2'd1,
    SIDE_LS   = 2'd2
  } side_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hb_dt_gap_timer.sv
// Saturating counter of cycles since the last switch-off in a channel.
module hb_dt_gap_timer #(
  parameter int unsigned SAT_VAL = 313,
  localparam int unsigned CNT_W  = $clog2(SAT_VAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT_VAL);

  always_ff @(posedge clk) begin
    if (rst)                count <= SAT_C;
    else if (restart)       count <= '0;
    else if (count != SAT_C) count <= count + 1'b1;
  end

endmodule

// File: rtl/hb_dt_channel.sv
// One half-bridge: non-overlapping enables with direction-dependent gap.
module hb_dt_channel
  import hb_dt_pkg::*;
#(
  parameter int unsigned DT_HL_CYC = 188,
  parameter int unsigned DT_LH_CYC = 313
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_req,
  input  logic ls_req,
  input  logic hs_kill,
  input  logic ls_kill,
  output logic hs_en,
  output logic ls_en
);

  localparam int unsigned SAT   = max_u(DT_HL_CYC, DT_LH_CYC);
  localparam int unsigned CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] HL_THR = CNT_W'(DT_HL_CYC - 1);
  localparam logic [CNT_W-1:0] LH_THR = CNT_W'(DT_LH_CYC - 1);

  logic             hs_q, ls_q, hs_d, ls_d;
  logic             hs_want, ls_want, hl_ok, lh_ok, restart;
  side_e            last_q;
  logic [CNT_W-1:0] gap_cnt;

  hb_dt_gap_timer #(.SAT_VAL(SAT)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .count   (gap_cnt)
  );

  always_comb begin
    hs_want = hs_req & ~hs_kill;
    ls_want = ls_req & ~ls_kill;
    hl_ok   = (last_q != SIDE_HS) || (gap_cnt >= HL_THR);
    lh_ok   = (last_q != SIDE_LS) || (gap_cnt >= LH_THR);
    hs_d    = 1'b0;
    ls_d    = 1'b0;
    if (hs_q)                     hs_d = hs_want;
    else if (ls_q)                ls_d = ls_want;
    else if (hs_want && !ls_want) hs_d = lh_ok;
    else if (ls_want && !hs_want) ls_d = hl_ok;
    restart = (hs_q & ~hs_d) | (ls_q & ~ls_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      last_q <= SIDE_NONE;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      if (hs_q && !hs_d)      last_q <= SIDE_HS;
      else if (ls_q && !ls_d) last_q <= SIDE_LS;
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;

  // Observers of how long each output has been low, from the outputs only.
  logic [CNT_W-1:0] hs_low_run, ls_low_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_low_run <= CNT_W'(SAT);
      ls_low_run <= CNT_W'(SAT);
    end else begin
      if (hs_q) hs_low_run <= '0;
      else if (hs_low_run != CNT_W'(SAT)) hs_low_run <= hs_low_run + 1'b1;
      if (ls_q) ls_low_run <= '0;
      else if (ls_low_run != CNT_W'(SAT)) ls_low_run <= ls_low_run + 1'b1;
    end
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(hs_q && ls_q));
  // R3
  hl_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> (hs_low_run >= CNT_W'(DT_HL_CYC)));
  // R4
  lh_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> (ls_low_run >= CNT_W'(DT_LH_CYC)));
  // R8
  hs_kill_chk: assert property (@(posedge clk) disable iff (rst) hs_kill |=> !hs_q);
  // R8
  ls_kill_chk: assert property (@(posedge clk) disable iff (rst) ls_kill |=> !ls_q);
  // R6
  keep_on_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_q && hs_req && ls_req && !hs_kill) |=> hs_q);
  // R7
  both_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hs_q && !ls_q && hs_req && ls_req) |=> (!hs_q && !ls_q));

endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq #(
  parameter int unsigned N_CH      = 6,
  parameter int unsigned DT_HL_CYC = 188,
  parameter int unsigned DT_LH_CYC = 313
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] hs_req,
  input  logic [N_CH-1:0] ls_req,
  input  logic [N_CH-1:0] hs_fault,
  input  logic [N_CH-1:0] ls_fault,
  input  logic            all_off,
  output logic [N_CH-1:0] hs_en,
  output logic [N_CH-1:0] ls_en
);

  logic [N_CH-1:0] hs_kill, ls_kill;
  assign hs_kill = hs_fault | {N_CH{all_off}};
  assign ls_kill = ls_fault | {N_CH{all_off}};

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    hb_dt_channel #(
      .DT_HL_CYC (DT_HL_CYC),
      .DT_LH_CYC (DT_LH_CYC)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .hs_req  (hs_req[i]),
      .ls_req  (ls_req[i]),
      .hs_kill (hs_kill[i]),
      .ls_kill (ls_kill[i]),
      .hs_en   (hs_en[i]),
      .ls_en   (ls_en[i])
    );
  end

  // R9
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    all_off |=> ((hs_en == '0) && (ls_en == '0)));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> ((hs_en == '0) && (ls_en == '0)));

endmodule

// File: tb/hb_deadtime_seq_tb.sv
module hb_deadtime_seq_tb;

  localparam int N  = 6;
  localparam int HL = 4;
  localparam int LH = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] hs_req = '0, ls_req = '0, hs_fault = '0, ls_fault = '0;
  logic all_off = 1'b0;
  logic [N-1:0] hs_en, ls_en;

  hb_deadtime_seq #(.N_CH(N), .DT_HL_CYC(HL), .DT_LH_CYC(LH)) u_dut (
    .clk(clk), .rst(rst), .hs_req(hs_req), .ls_req(ls_req),
    .hs_fault(hs_fault), .ls_fault(ls_fault), .all_off(all_off),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    cyc;
    int    ch;
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, overlap_seen = 0;
  bit done = 0;

  // Driver side: expectation for channel ch, dly cycles after this negedge.
  task automatic expect_ch(input int dly, input int ch, input logic h,
                           input logic l, input string tag);
    exp_t e;
    e.cyc = cyc + dly; e.ch = ch; e.hs = h; e.ls = l; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare due items
  always @(negedge clk) begin
    if (!rst && ((hs_en & ls_en) != '0)) overlap_seen++;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        checks++;
        if (hs_en[q[i].ch] !== q[i].hs || ls_en[q[i].ch] !== q[i].ls) begin
          errors++;
          $display("FAIL %s ch%0d cyc%0d: hs,ls=%b,%b expected %b,%b", q[i].tag,
                   q[i].ch, cyc, hs_en[q[i].ch], ls_en[q[i].ch], q[i].hs, q[i].ls);
        end
        q.delete(i);
      end else if (q[i].cyc < cyc) begin
        checks++; errors++;
        $display("FAIL %s ch%0d: sample at cyc%0d missed, actual none expected %b,%b",
                 q[i].tag, q[i].ch, q[i].cyc, q[i].hs, q[i].ls);
        q.delete(i);
      end
    end
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < N; c++) expect_ch(1, c, 1'b0, 1'b0, "R1");
    step(3);
    rst = 1'b0;
    for (int c = 0; c < N; c++) expect_ch(1, c, 1'b0, 1'b0, "R1");
    step(2);

    // R5: first turn-on from idle
    hs_req[0] = 1'b1;
    expect_ch(1, 0, 1'b1, 1'b0, "R5");
    step(3);

    // R3: high-to-low changeover
    hs_req[0] = 1'b0; ls_req[0] = 1'b1;
    expect_ch(1, 0, 1'b0, 1'b0, "R3");
    expect_ch(HL, 0, 1'b0, 1'b0, "R3");
    expect_ch(HL + 1, 0, 1'b0, 1'b1, "R3");
    step(HL + 3);

    // R4: low-to-high changeover
    ls_req[0] = 1'b0; hs_req[0] = 1'b1;
    expect_ch(1, 0, 1'b0, 1'b0, "R4");
    expect_ch(LH, 0, 1'b0, 1'b0, "R4");
    expect_ch(LH + 1, 0, 1'b1, 1'b0, "R4");
    step(LH + 3);

    // R6: conflicting request while high side on
    ls_req[0] = 1'b1;
    expect_ch(2, 0, 1'b1, 1'b0, "R6");
    expect_ch(5, 0, 1'b1, 1'b0, "R6");
    step(6);

    // R8: forced off, then same side resumes
    ls_req[0] = 1'b0; hs_fault[0] = 1'b1;
    expect_ch(1, 0, 1'b0, 1'b0, "R8");
    step(2);
    hs_fault[0] = 1'b0;
    expect_ch(1, 0, 1'b1, 1'b0, "R8");
    step(2);

    // R8 with changeover in the same cycle, R10 neighbour untouched
    ls_req[1] = 1'b1;
    expect_ch(1, 1, 1'b0, 1'b1, "R5");
    step(3);
    ls_fault[1] = 1'b1; ls_req[1] = 1'b0; hs_req[1] = 1'b1;
    expect_ch(1, 1, 1'b0, 1'b0, "R8");
    expect_ch(1, 0, 1'b1, 1'b0, "R10");
    expect_ch(LH, 1, 1'b0, 1'b0, "R8");
    expect_ch(LH + 1, 1, 1'b1, 1'b0, "R8");
    step(1);
    ls_fault[1] = 1'b0;
    step(LH + 2);

    // R7: both requested from idle
    hs_req[2] = 1'b1; ls_req[2] = 1'b1;
    expect_ch(1, 2, 1'b0, 1'b0, "R7");
    expect_ch(4, 2, 1'b0, 1'b0, "R7");
    expect_ch(4, 3, 1'b0, 1'b0, "R10");
    step(4);
    hs_req[2] = 1'b0;
    expect_ch(1, 2, 1'b0, 1'b1, "R7");
    step(2);

    // R6: low side on keeps priority
    hs_req[2] = 1'b1;
    expect_ch(3, 2, 1'b0, 1'b1, "R6");
    step(4);

    // R9: global off, then release
    all_off = 1'b1;
    for (int c = 0; c < 3; c++) expect_ch(1, c, 1'b0, 1'b0, "R9");
    step(1);
    all_off = 1'b0;
    expect_ch(1, 0, 1'b1, 1'b0, "R9");
    expect_ch(1, 1, 1'b1, 1'b0, "R9");
    expect_ch(1, 2, 1'b0, 1'b0, "R7");
    step(3);

    while (q.size() != 0) @(negedge clk);
    checks++;
    if (overlap_seen != 0) begin
      errors++;
      $display("FAIL R2: overlap cycles=%0d expected 0", overlap_seen);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual incomplete expected complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule